// File: doc/BRIEF.md
# Flag-Aligned Byte Stream Repacker

This block takes a byte stream that arrives eight bytes per clock as one wide word, with the earliest byte in the most significant lane. The octet 0x7E marks the boundary between frames. A single flag both closes the frame before it and opens the frame after it. The flag can sit in any lane, and its lane changes from frame to frame. The block removes the flags and throws away any bytes that come before the first flag. It then repacks the payload of each frame so that the first byte of every frame lands in the most significant lane of a new output word. Each output word carries a byte count and an end-of-frame marker. Full words carry eight bytes. A frame's final word carries one to eight bytes, and the lanes past its count are zero.

Both sides use valid/ready handshakes. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is taken on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word and its sidebands hold still. The block lowers `in_ready` when it cannot accept data. This happens while it works through the bytes that follow a flag inside a held word. It also happens for one extra cycle when a frame closes with more than eight bytes pending, because the block then has to emit two words. `in_ready` depends on `out_ready` through combinational logic.

Top module: `flag_repacker`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Bytes that arrive before the first 0x7E flag produce no output.
- R3: Flag octets never appear in output lanes. Payload bytes leave in stream order, and each frame starts in the most significant lane (bits 63:56) of a new word.
- R4: `out_count` (4 bits) is 8 on every word that is not the last word of a frame. The last word of a frame has `out_count` from 1 to 8 with `out_last` high.
- R5: No byte is lost or repeated when the flag lane differs from one frame to the next.
- R6: Several flags inside one input word, which delimit short frames, each produce the correct frames.
- R7: Two flags with no bytes between them produce no output word.
- R8: A frame whose length is a multiple of 8 and whose closing flag arrives in a later input word ends with an 8-byte word that has `out_last` high.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_count` and `out_last` stay stable, and no word is dropped.
- R10: Input words are taken only on edges where `in_valid` and `in_ready` are both high. Gaps in `in_valid` do not change the output.
- R11: When a frame closes with more than 8 bytes pending, the block emits one full word followed by a final word with `out_last` high, and holds the input back in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word on this edge |
| in_data | input | 64 | Eight byte lanes; lane 0 in bits 63:56 is earliest |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink accepts the output word on this edge |
| out_data | output | 64 | Repacked payload; first byte in bits 63:56 |
| out_count | output | 4 | Number of valid bytes, 1 to 8 |
| out_last | output | 1 | Word ends a frame |

## Verification
A wrong carry fill or read offset shows at the ports as a shifted, missing or repeated byte in the next word that leaves the block. Such an error therefore surfaces within a few transfers of the flag that exposed it. A frame-state error shows as a garbage byte or as a whole missing frame at the next flag. A lost pending flush shows as a word with `out_last` high arriving one frame late, or not arriving at all. The scoreboard compares every transfer, in order, against a byte-level model of the stream. Random stalls on both sides expose handshake slips as mismatches.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef logic [7:0] octet_t;
  localparam octet_t DEFAULT_FLAG = 8'h7E;
endpackage

// File: rtl/frm_flag_scan.sv
// Finds the first flag lane at or after a start lane; returns LANES if none.
module frm_flag_scan
  import frm_pkg::*;
#(
  parameter int     LANES = 8,
  parameter int     CW    = $clog2(LANES + 1),
  parameter octet_t FLAG  = DEFAULT_FLAG
) (
  input  octet_t          lanes_i [LANES],
  input  logic [CW-1:0]   from_i,
  output logic [CW-1:0]   hit_lane_o
);
  logic [LANES-1:0] hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [CW-1:0] IDX = CW'(g);
    assign hit[g] = (lanes_i[g] == FLAG) && (IDX >= from_i);
  end

  always_comb begin
    hit_lane_o = CW'(LANES);
    for (int i = LANES - 1; i >= 0; i--) begin
      if (hit[i]) hit_lane_o = CW'(i);
    end
  end
endmodule

// File: rtl/frm_merge.sv
// Appends `take_i` lanes of the held word, starting at `off_i`, behind the carry.
module frm_merge
  import frm_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CW    = $clog2(LANES + 1),
  parameter int TW    = $clog2(2 * LANES + 1)
) (
  input  octet_t        carry_i  [LANES],
  input  logic [CW-1:0] fill_i,
  input  octet_t        lanes_i  [LANES],
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] take_i,
  output octet_t        merged_o [2*LANES],
  output logic [TW-1:0] total_o
);
  localparam int SLOTS = 2 * LANES;

  always_comb begin
    int f;
    int o;
    int t;
    int j;
    f = int'(fill_i);
    o = int'(off_i);
    t = int'(take_i);
    for (int k = 0; k < SLOTS; k++) begin
      merged_o[k] = '0;
      j = k - f;
      if (k < f) begin
        for (int s = 0; s < LANES; s++) begin
          if (s == k) merged_o[k] = carry_i[s];
        end
      end else if (j < t) begin
        for (int s = 0; s < LANES; s++) begin
          if (s == o + j) merged_o[k] = lanes_i[s];
        end
      end
    end
  end

  assign total_o = TW'(fill_i) + TW'(take_i);
endmodule

// File: rtl/flag_repacker.sv
module flag_repacker
  import frm_pkg::*;
#(
  parameter int     LANES = 8,
  parameter octet_t FLAG  = DEFAULT_FLAG,
  localparam int    DW    = LANES * 8,
  localparam int    CW    = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_count,
  output logic          out_last
);
  localparam int              TW     = $clog2(2 * LANES + 1);
  localparam logic [TW-1:0]   FULL_T = TW'(LANES);
  localparam logic [CW-1:0]   NONE   = CW'(LANES);

  // held input word and read offset
  logic          hold_vld;
  logic [DW-1:0] hold_data;
  logic [CW-1:0] hold_off;
  octet_t        hold_lanes [LANES];

  // frame state and carry
  logic          in_frame, in_frame_n;
  logic          pend, pend_n;
  octet_t        carry   [LANES];
  octet_t        carry_n [LANES];
  logic [CW-1:0] fill, fill_n;

  logic [CW-1:0] flag_lane, take, off_n;
  octet_t        merged [2*LANES];
  logic [TW-1:0] total;

  logic          adv, consumed;
  logic          emit, emit_last;
  logic [CW-1:0] emit_cnt;
  octet_t        emit_bytes [LANES];
  logic [DW-1:0] emit_word;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign hold_lanes[g] = hold_data[(LANES-1-g)*8 +: 8];
  end

  frm_flag_scan #(.LANES(LANES), .CW(CW), .FLAG(FLAG)) u_scan (
    .lanes_i    (hold_lanes),
    .from_i     (hold_off),
    .hit_lane_o (flag_lane)
  );

  assign take = in_frame ? (flag_lane - hold_off) : '0;

  frm_merge #(.LANES(LANES), .CW(CW), .TW(TW)) u_merge (
    .carry_i  (carry),
    .fill_i   (fill),
    .lanes_i  (hold_lanes),
    .off_i    (hold_off),
    .take_i   (take),
    .merged_o (merged),
    .total_o  (total)
  );

  assign adv = !out_valid || out_ready;

  always_comb begin
    emit       = 1'b0;
    emit_last  = 1'b0;
    emit_cnt   = '0;
    fill_n     = fill;
    off_n      = hold_off;
    in_frame_n = in_frame;
    pend_n     = pend;
    for (int i = 0; i < LANES; i++) begin
      emit_bytes[i] = merged[i];
      carry_n[i]    = carry[i];
    end
    if (adv) begin
      if (pend) begin
        // second word of a split close: flush the carry
        emit      = 1'b1;
        emit_last = 1'b1;
        emit_cnt  = fill;
        for (int i = 0; i < LANES; i++) emit_bytes[i] = carry[i];
        fill_n    = '0;
        pend_n    = 1'b0;
      end else if (hold_vld) begin
        off_n = (flag_lane != NONE) ? flag_lane + CW'(1) : NONE;
        if (!in_frame) begin
          in_frame_n = (flag_lane != NONE);
        end else if (flag_lane != NONE) begin
          if (total > FULL_T) begin
            emit     = 1'b1;
            emit_cnt = CW'(LANES);
            for (int i = 0; i < LANES; i++) carry_n[i] = merged[LANES+i];
            fill_n   = CW'(total - FULL_T);
            pend_n   = 1'b1;
          end else begin
            emit      = (total != '0);
            emit_last = (total != '0);
            emit_cnt  = CW'(total);
            fill_n    = '0;
          end
        end else begin
          if (total > FULL_T) begin
            emit     = 1'b1;
            emit_cnt = CW'(LANES);
            for (int i = 0; i < LANES; i++) carry_n[i] = merged[LANES+i];
            fill_n   = CW'(total - FULL_T);
          end else begin
            for (int i = 0; i < LANES; i++) carry_n[i] = merged[i];
            fill_n = CW'(total);
          end
        end
      end
    end
  end

  assign consumed = hold_vld && adv && !pend && (off_n == NONE);
  assign in_ready = !hold_vld || consumed;

  always_comb begin
    for (int i = 0; i < LANES; i++) emit_word[(LANES-1-i)*8 +: 8] = emit_bytes[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
      hold_off  <= '0;
    end else if (in_valid && in_ready) begin
      hold_vld  <= 1'b1;
      hold_data <= in_data;
      hold_off  <= '0;
    end else if (hold_vld && adv && !pend) begin
      hold_off  <= off_n;
      if (consumed) hold_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      pend     <= 1'b0;
      fill     <= '0;
      for (int i = 0; i < LANES; i++) carry[i] <= '0;
    end else begin
      in_frame <= in_frame_n;
      pend     <= pend_n;
      fill     <= fill_n;
      for (int i = 0; i < LANES; i++) carry[i] <= carry_n[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_count <= '0;
      out_last  <= 1'b0;
    end else if (adv) begin
      out_valid <= emit;
      out_data  <= emit_word;
      out_count <= emit_cnt;
      out_last  <= emit_last;
    end
  end
endmodule

// File: rtl/frm_repack_chk.sv
module frm_repack_chk
  import frm_pkg::*;
#(
  parameter int     LANES = 8,
  parameter octet_t FLAG  = DEFAULT_FLAG,
  localparam int    DW    = LANES * 8,
  localparam int    CW    = $clog2(LANES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_count,
  input logic          out_last
);
  function automatic logic has_flag(logic [DW-1:0] d, logic [CW-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (CW'(i) < c && d[(LANES-1-i)*8 +: 8] == FLAG) r = 1'b1;
    end
    return r;
  endfunction

  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= CW'(1) && out_count <= CW'(LANES)));

  p_full_unless_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_count == CW'(LANES)));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_count) && $stable(out_last)));

  p_no_flag_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !has_flag(out_data, out_count));
endmodule

bind flag_repacker frm_repack_chk #(.LANES(LANES), .FLAG(FLAG)) chk_i (.*);

// File: tb/flag_repacker_tb_top.sv
module flag_repacker_tb_top;
  localparam int LANES = 8;
  localparam int CW    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic [CW-1:0] out_count;
  logic        out_last;

  always #4 clk = ~clk;

  flag_repacker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_count(out_count), .out_last(out_last)
  );

  typedef struct {
    logic [63:0] data;
    int          cnt;
    bit          last;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  tx_q[$];
  logic [7:0]  m_buf[$];
  bit          m_in_frame = 1'b0;
  bit          bp_mode = 1'b0;
  string       cur_tag = "R3";
  int          n_chk = 0;
  int          n_fail = 0;

  task automatic flush_model();
    while (m_buf.size() > 0) begin
      exp_t e;
      e.data = '0;
      e.cnt  = (m_buf.size() > 8) ? 8 : m_buf.size();
      for (int i = 0; i < e.cnt; i++) e.data[63-8*i -: 8] = m_buf.pop_front();
      e.last = (m_buf.size() == 0);
      e.tag  = cur_tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic put_byte(logic [7:0] b);
    tx_q.push_back(b);
    if (b == 8'h7E) begin
      if (m_in_frame) flush_model();
      m_in_frame = 1'b1;
      m_buf.delete();
    end else if (m_in_frame) begin
      m_buf.push_back(b);
    end
  endtask

  // payload of `len` bytes then a closing flag
  task automatic put_frame(int len, int seed);
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      v = 8'((seed + 3 * i + 1) & 255);
      if (v == 8'h7E) v = 8'h7D;
      put_byte(v);
    end
    put_byte(8'h7E);
  endtask

  task automatic drive_stream();
    while (tx_q.size() % 8 != 0) put_byte(8'h7E);
    while (tx_q.size() >= 8) begin
      logic [63:0] w;
      for (int i = 0; i < 8; i++) w[63-8*i -: 8] = tx_q.pop_front();
      forever begin
        @(negedge clk);
        if (bp_mode && ($urandom % 3 == 0)) begin
          in_valid = 1'b0;
          in_data  = '1;
        end else begin
          in_valid = 1'b1;
          in_data  = w;
          #1;
          if (in_ready) begin
            @(posedge clk);
            break;
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = bp_mode ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R3 unexpected word: actual=%h cnt=%0d last=%0b expected=none",
                   out_data, out_count, out_last);
        end else begin
          exp_t e;
          bit ok;
          e  = exp_q.pop_front();
          ok = (int'(out_count) == e.cnt) && (out_last == e.last);
          for (int i = 0; i < 8; i++)
            if (i < e.cnt && out_data[63-8*i -: 8] != e.data[63-8*i -: 8]) ok = 1'b0;
          if (!ok) begin
            n_fail++;
            $display("FAIL %s word: actual=%h cnt=%0d last=%0b expected=%h cnt=%0d last=%0b",
                     e.tag, out_data, out_count, out_last, e.data, e.cnt, e.last);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=stream drained");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: actual valid=%0b ready=%0b expected valid=0 ready=1",
               out_valid, in_ready);
    end

    // R2: leading garbage dropped
    cur_tag = "R2";
    put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
    put_byte(8'h7E);
    put_frame(12, 16);
    drive_stream();

    // R3: ordering and lane-0 start
    cur_tag = "R3";
    put_frame(5, 40); put_frame(7, 60);
    drive_stream();

    // R4: full words then a partial last word
    cur_tag = "R4";
    put_frame(20, 80); put_frame(3, 9);
    drive_stream();

    // R5: flag lane moves every frame
    cur_tag = "R5";
    put_frame(3, 1); put_frame(9, 2); put_frame(13, 3); put_frame(6, 4); put_frame(17, 5);
    drive_stream();

    // R6: several flags per input word
    cur_tag = "R6";
    put_frame(1, 7); put_frame(2, 8); put_frame(1, 9); put_frame(3, 10); put_frame(1, 11);
    drive_stream();

    // R7: back-to-back flags are empty frames
    cur_tag = "R7";
    put_byte(8'h7E); put_byte(8'h7E); put_byte(8'h7E);
    put_frame(4, 30);
    drive_stream();

    // R8: multiples of 8 closed in a later word
    cur_tag = "R8";
    for (int k = 0; k < 8; k++) begin
      put_frame(8, 50 + k);
      put_frame(16, 90 + k);
    end
    drive_stream();

    // R11: close with more than 8 pending bytes
    cur_tag = "R11";
    for (int len = 9; len <= 15; len++) put_frame(len, len * 5);
    drive_stream();

    // R9 / R10: random stalls on both sides
    bp_mode = 1'b1;
    cur_tag = "R9";
    for (int k = 0; k < 40; k++) put_frame(int'($urandom % 20), k);
    drive_stream();
    cur_tag = "R10";
    for (int k = 0; k < 40; k++) put_frame(int'($urandom % 12), 3 * k);
    drive_stream();

    for (int t = 0; t < 2000 && exp_q.size() > 0; t++) @(posedge clk);
    bp_mode = 1'b0;
    repeat (20) @(posedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 missing words: actual=%0d left expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule